// File: doc/BRIEF.md
# Bus clock prescaler with timer doubling

This block turns one system clock into a set of single-cycle enable strobes. A high-speed bus strobe is produced by a power-of-two prescaler. Two peripheral bus strobes are produced by further prescalers that count high-speed bus strobes. Each peripheral bus has a companion timer strobe that runs at twice its bus rate whenever that bus prescaler is not 1:1. A system timer tick fires once every eight high-speed bus strobes. Every strobe stays in the input clock domain, so downstream logic uses it as a clock enable rather than as a clock.

The prescaler codes and a 2-bit clock source selection come from one 32-bit configuration word. Software may rewrite it at any time. A divider adopts a new code only when it reaches its own terminal count, so a period already in progress always finishes at its old length and no strobe comes early. The source selection is only registered and presented on a port for the clock multiplexer that sits outside this block.

Top module: `busclk_prescaler`

## Requirements
- R1: The high-speed prescaler code is configuration bits 7:4. Codes 0 to 7 give a strobe on every cycle. Codes 8 to 15 give one strobe every 2, 4, 8, 16, 64, 128, 256 and 512 cycles respectively, so a period of 32 cannot be selected.
- R2: Peripheral bus A takes its code from bits 12:10 and bus B from bits 15:13. Each bus counts high-speed strobes. Codes 0 to 3 give a bus strobe on every high-speed strobe. Codes 4, 5, 6 and 7 give one bus strobe every 2, 4, 8 and 16 high-speed strobes. Each bus strobe coincides with a high-speed strobe.
- R3: When a peripheral code selects a ratio above 1, its timer strobe fires twice per bus period: once at the middle of the period and once on the same cycle as the bus strobe. Each timer strobe coincides with a high-speed strobe.
- R4: When a peripheral code selects 1:1, its timer strobe is identical to its bus strobe.
- R5: The system timer tick fires on every eighth high-speed strobe.
- R6: `src_sel` presents configuration bits 1:0 from the cycle after the write. The values mean 0 for the internal oscillator, 1 for the external oscillator and 2 for the PLL.
- R7: A new code takes effect only at the next terminal count of the divider it controls. The period in progress when the write arrives ends at its old length.
- R8: A synchronous active-low reset clears every divider count, sets every code and the source field to 0, and holds all strobes low for as long as it is asserted.
- R9: Configuration bits outside the four fields (bits 3:2, 9:8 and 31:16) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are enables in this domain |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to be written |
| src_sel | output | 2 | Registered clock source selection field |
| hb_stb | output | 1 | High-speed bus enable strobe |
| pb_stb | output | NUM_PB | Peripheral bus enable strobes, bit 0 for bus A |
| pb_tmr_stb | output | NUM_PB | Peripheral timer enable strobes, bit 0 for bus A |
| sys_tick_stb | output | 1 | System timer tick, high-speed rate divided by 8 |

## Verification
The bench builds the block with its default parameters: two peripheral buses, the field positions listed above, a deepest high-speed ratio of 512 and a deepest peripheral ratio of 16. At these sizes every code of both prescaler kinds can be measured within one run. This includes the longest chains, with a 1024-cycle bus period and a 4096-cycle system tick. Timer doubling is checked by measuring the timer period against the bus period. Writes that land partway through a long period are used to show that a new code waits for the terminal count.

// File: rtl/busclk_prescaler_pkg.sv
// Package: code-to-shift decoding shared by the configuration register and the bench.
// Assumes codes arrive as raw register fields; divide ratios are powers of two.
package busclk_prescaler_pkg;

    // Width of the raw prescaler code fields.
    localparam int HB_CODE_W = 4;
    localparam int PB_CODE_W = 3;

    // Largest log2 ratio each prescaler can select.
    localparam int HB_MAX_SHIFT = 9;
    localparam int PB_MAX_SHIFT = 4;

    // High-speed code to log2 ratio: upper half of codes is sparse and skips 2^5.
    function automatic int unsigned hb_code_shift(input logic [HB_CODE_W-1:0] code);
        if (!code[3]) begin
            return 0;
        end
        if (code[2]) begin
            return int'(code[2:0]) + 2;
        end
        return int'(code[2:0]) + 1;
    endfunction

    // Peripheral code to log2 ratio: lower half of codes is 1:1.
    function automatic int unsigned pb_code_shift(input logic [PB_CODE_W-1:0] code);
        if (!code[2]) begin
            return 0;
        end
        return int'(code[1:0]) + 1;
    endfunction

endpackage

// File: rtl/busclk_prescaler_cfg.sv
// Module: configuration register.
// Holds only the source field and the prescaler code fields of the written word.
// It presents the prescaler codes already decoded into log2 divide ratios.
// Assumes a single writer; bits outside the fields are dropped at the input.
module busclk_prescaler_cfg
    import busclk_prescaler_pkg::*;
#(
    parameter int CFG_W   = 32,
    parameter int SRC_LSB = 0,
    parameter int HB_LSB  = 4,
    parameter int PB_LSB  = 10,
    parameter int NUM_PB  = 2,
    parameter int HB_SH_W = 4,
    parameter int PB_SH_W = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [CFG_W-1:0]                wdata,
    output logic [1:0]                      src_sel,
    output logic [HB_SH_W-1:0]              hb_shift,
    output logic [NUM_PB-1:0][PB_SH_W-1:0]  pb_shift
);

    logic [1:0]                         src_q;
    logic [HB_CODE_W-1:0]               hb_code_q;
    logic [NUM_PB-1:0][PB_CODE_W-1:0]   pb_code_q;
    logic                               cfg_unused_parity;

    // Bits outside the fields are intentionally not stored.
    assign cfg_unused_parity = ^wdata;

    // Capture the source and high-speed fields on a write; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q     <= '0;
            hb_code_q <= '0;
        end else if (wr) begin
            src_q     <= wdata[SRC_LSB +: 2];
            hb_code_q <= wdata[HB_LSB +: HB_CODE_W];
        end
    end

    // One code register and decoder per peripheral bus, at consecutive field positions.
    for (genvar g = 0; g < NUM_PB; g++) begin : g_pb_field
        localparam int FIELD_LSB = PB_LSB + g * PB_CODE_W;

        // Capture this bus's code field on a write; clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pb_code_q[g] <= '0;
            end else if (wr) begin
                pb_code_q[g] <= wdata[FIELD_LSB +: PB_CODE_W];
            end
        end

        // Decode the stored code into a log2 ratio.
        assign pb_shift[g] = PB_SH_W'(pb_code_shift(pb_code_q[g]));
    end

    // Decode the stored high-speed code into a log2 ratio.
    assign hb_shift = HB_SH_W'(hb_code_shift(hb_code_q));
    assign src_sel  = src_q;

endmodule

// File: rtl/busclk_prescaler_div.sv
// Module: power-of-two enable divider with a mid-period tap.
// Counts qualifying input ticks and strobes on the last tick of each period.
// The half strobe marks both the middle and the end of the period, so it runs
// at twice the period rate when the ratio is above 1 and equals the main strobe
// at 1:1. A requested ratio is adopted only at the terminal count.
// Assumes shift_req never exceeds MAX_SH.
module busclk_prescaler_div #(
    parameter int MAX_SH = 9,
    parameter int SH_W   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_in,
    input  logic [SH_W-1:0] shift_req,
    output logic            stb,
    output logic            half_stb
);

    localparam int CNT_W = (MAX_SH > 0) ? MAX_SH : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  cur_sh_q;
    logic [CNT_W-1:0] term_mask;
    logic [CNT_W-1:0] half_mask;
    logic             at_term;
    logic             at_half;

    // Terminal value is 2^shift - 1; the half tap matches the lower shift-1 bits.
    always_comb begin
        term_mask = ~({CNT_W{1'b1}} << cur_sh_q);
        half_mask = term_mask >> 1;
        at_term   = (cnt_q == term_mask);
        at_half   = ((cnt_q & half_mask) == half_mask);
    end

    // Advance on each qualifying tick; wrap and adopt the new ratio at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cur_sh_q <= '0;
        end else if (tick_in) begin
            if (at_term) begin
                cnt_q    <= '0;
                cur_sh_q <= shift_req;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign stb      = rst_n & tick_in & at_term;
    assign half_stb = rst_n & tick_in & at_half;

endmodule

// File: rtl/busclk_prescaler_tick.sv
// Module: fixed power-of-two tick divider.
// Emits one strobe for every 2^LOG2 qualifying input ticks.
// Assumes the input tick is a single-cycle enable in the same clock domain.
module busclk_prescaler_tick #(
    parameter int LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic stb
);

    logic [LOG2-1:0] cnt_q;

    // Count qualifying ticks; the counter wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_in) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stb = rst_n & tick_in & (cnt_q == {LOG2{1'b1}});

endmodule

// File: rtl/busclk_prescaler.sv
// Module: bus clock prescaler top.
// Builds the high-speed bus strobe from the system clock and the peripheral bus
// and timer strobes from the high-speed strobe. It also builds the system timer
// tick and registers the clock source field.
// Assumes all consumers treat the outputs as clock enables in the clk domain.
module busclk_prescaler
    import busclk_prescaler_pkg::*;
#(
    parameter int CFG_W    = 32,
    parameter int SRC_LSB  = 0,
    parameter int HB_LSB   = 4,
    parameter int PB_LSB   = 10,
    parameter int NUM_PB   = 2,
    parameter int SYS_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [1:0]        src_sel,
    output logic              hb_stb,
    output logic [NUM_PB-1:0] pb_stb,
    output logic [NUM_PB-1:0] pb_tmr_stb,
    output logic              sys_tick_stb
);

    localparam int HB_SH_W = $clog2(HB_MAX_SHIFT + 1);
    localparam int PB_SH_W = $clog2(PB_MAX_SHIFT + 1);

    logic [HB_SH_W-1:0]             hb_shift;
    logic [NUM_PB-1:0][PB_SH_W-1:0] pb_shift;
    logic                           hb_half_unused;

    busclk_prescaler_cfg #(
        .CFG_W   (CFG_W),
        .SRC_LSB (SRC_LSB),
        .HB_LSB  (HB_LSB),
        .PB_LSB  (PB_LSB),
        .NUM_PB  (NUM_PB),
        .HB_SH_W (HB_SH_W),
        .PB_SH_W (PB_SH_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .src_sel  (src_sel),
        .hb_shift (hb_shift),
        .pb_shift (pb_shift)
    );

    // High-speed divider runs on every system clock cycle.
    busclk_prescaler_div #(
        .MAX_SH (HB_MAX_SHIFT),
        .SH_W   (HB_SH_W)
    ) u_hb_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (1'b1),
        .shift_req (hb_shift),
        .stb       (hb_stb),
        .half_stb  (hb_half_unused)
    );

    // One peripheral divider per bus, each counting high-speed strobes.
    for (genvar g = 0; g < NUM_PB; g++) begin : g_pb_div
        busclk_prescaler_div #(
            .MAX_SH (PB_MAX_SHIFT),
            .SH_W   (PB_SH_W)
        ) u_pb_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_in   (hb_stb),
            .shift_req (pb_shift[g]),
            .stb       (pb_stb[g]),
            .half_stb  (pb_tmr_stb[g])
        );
    end

    // System timer tick counts high-speed strobes.
    busclk_prescaler_tick #(
        .LOG2 (SYS_LOG2)
    ) u_sys_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_in (hb_stb),
        .stb     (sys_tick_stb)
    );

endmodule

// File: rtl/busclk_prescaler_chk.sv
// Module: assertion checker for the bus clock prescaler, bound to the top.
// Observes ports only and keeps its own count of high-speed strobes.
module busclk_prescaler_chk #(
    parameter int CFG_W  = 32,
    parameter int NUM_PB = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic [1:0]        src_sel,
    input logic              hb_stb,
    input logic [NUM_PB-1:0] pb_stb,
    input logic [NUM_PB-1:0] pb_tmr_stb,
    input logic              sys_tick_stb
);

    logic [2:0] hb_since_tick;

    // Count high-speed strobes since the last system tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hb_since_tick <= '0;
        end else if (sys_tick_stb) begin
            hb_since_tick <= '0;
        end else if (hb_stb) begin
            hb_since_tick <= hb_since_tick + 1'b1;
        end
    end

    // Strobes are quiet while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!hb_stb && pb_stb == '0 && pb_tmr_stb == '0 && !sys_tick_stb); // R8
        end
    end

    AST_SRC_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (src_sel == $past(cfg_wdata[1:0]))); // R6

    AST_SYS_ON_HB: assert property (@(posedge clk) disable iff (!rst_n)
        sys_tick_stb |-> hb_stb); // R5

    AST_SYS_EIGHTH: assert property (@(posedge clk) disable iff (!rst_n)
        sys_tick_stb |-> (hb_since_tick == 3'd7)); // R5

    for (genvar g = 0; g < NUM_PB; g++) begin : g_pb_chk
        AST_BUS_ON_HB: assert property (@(posedge clk) disable iff (!rst_n)
            pb_stb[g] |-> hb_stb); // R2

        AST_TMR_ON_HB: assert property (@(posedge clk) disable iff (!rst_n)
            pb_tmr_stb[g] |-> hb_stb); // R3

        AST_TMR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            pb_stb[g] |-> pb_tmr_stb[g]); // R3
    end

endmodule

bind busclk_prescaler busclk_prescaler_chk #(
    .CFG_W  (CFG_W),
    .NUM_PB (NUM_PB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .src_sel      (src_sel),
    .hb_stb       (hb_stb),
    .pb_stb       (pb_stb),
    .pb_tmr_stb   (pb_tmr_stb),
    .sys_tick_stb (sys_tick_stb)
);

// File: tb/busclk_prescaler_bench.sv
// Bench: table-driven period measurement followed by directed reset and code-change tests.
module busclk_prescaler_bench;

    localparam int NV = 10;

    // Configuration words: src | hb<<4 | busA<<10 | busB<<13 (V2 also sets unused bits).
    localparam logic [31:0] VEC_CFG [NV] = '{
        32'h0000_0000, 32'h0000_F081, 32'hFFFF_573E, 32'h0000_CCC0, 32'h0000_98B1,
        32'h0000_BC92, 32'h0000_80F0, 32'h0000_00D1, 32'h0000_10E0, 32'h0000_64A2
    };
    localparam logic [1:0] VEC_SRC [NV] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd0, 2'd2};
    // Expected periods: hb, busA, tmrA, busB, tmrB, sys.
    localparam int VEC_PER [NV][6] = '{
        '{1, 1, 1, 1, 1, 8},
        '{2, 4, 2, 32, 16, 16},
        '{1, 4, 2, 1, 1, 8},
        '{64, 64, 64, 512, 256, 512},
        '{16, 128, 64, 32, 16, 128},
        '{4, 64, 32, 16, 8, 32},
        '{512, 512, 512, 1024, 512, 4096},
        '{128, 128, 128, 128, 128, 1024},
        '{256, 512, 256, 256, 256, 2048},
        '{8, 8, 8, 8, 8, 64}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  src_sel;
    logic        hb_stb;
    logic [1:0]  pb_stb;
    logic [1:0]  pb_tmr_stb;
    logic        sys_tick_stb;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    busclk_prescaler u_busclk_prescaler (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_wdata    (cfg_wdata),
        .src_sel      (src_sel),
        .hb_stb       (hb_stb),
        .pb_stb       (pb_stb),
        .pb_tmr_stb   (pb_tmr_stb),
        .sys_tick_stb (sys_tick_stb)
    );

    function automatic logic sig(input int sel);
        case (sel)
            0: return hb_stb;
            1: return pb_stb[0];
            2: return pb_tmr_stb[0];
            3: return pb_stb[1];
            4: return pb_tmr_stb[1];
            default: return sys_tick_stb;
        endcase
    endfunction

    task automatic check(input string req, input int actual, input int expected, input string what);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_strobes(input int sel, input int n);
        for (int k = 0; k < n; k++) begin
            do @(negedge clk); while (!sig(sel));
        end
    endtask

    // Interval in cycles between the next two strobes of a signal.
    task automatic measure(input int sel, output int per);
        do @(negedge clk); while (!sig(sel));
        per = 0;
        do begin
            @(negedge clk);
            per++;
        end while (!sig(sel));
    endtask

    // Write a new word two cycles after a strobe; the old period must still complete (R7).
    task automatic early_test(input int sel, input logic [31:0] v, input int old_per, input int new_per);
        int per;
        do @(negedge clk); while (!sig(sel));
        per = 0;
        do begin
            @(negedge clk);
            per++;
            if (per == 2) begin
                cfg_wr = 1'b1;
                cfg_wdata = v;
            end else begin
                cfg_wr = 1'b0;
            end
        end while (!sig(sel));
        cfg_wr = 1'b0;
        check("R7", per, old_per, "period in progress at code change");
        measure(sel, per);
        check("R7", per, new_per, "period after terminal count");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int per;
        int cnt;
        // R8: strobes stay low while reset is held.
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            check("R8", int'({hb_stb, pb_stb, pb_tmr_stb, sys_tick_stb}), 0, "strobes in reset");
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", int'(src_sel), 0, "src after reset");

        // Table walk: R1 R2 R3 R4 R5 R6 R9.
        for (int v = 0; v < NV; v++) begin
            write_cfg(VEC_CFG[v]);
            check("R6", int'(src_sel), int'(VEC_SRC[v]), $sformatf("src vec %0d", v));
            wait_strobes(0, 2);
            wait_strobes(1, 2);
            wait_strobes(3, 2);
            for (int s = 0; s < 6; s++) begin
                measure(s, per);
                check(s == 0 ? "R1" : (s == 5 ? "R5" : ((s == 2 || s == 4) ? "R3" : "R2")),
                      per, VEC_PER[v][s], $sformatf("vec %0d period sel %0d (R4 R9 where 1:1/junk)", v, s));
                if (s == 1 || s == 3) begin
                    check("R3", int'(sig(s + 1)), 1, $sformatf("timer aligned with bus, vec %0d sel %0d", v, s));
                end
            end
        end

        // R7 on the high-speed divider: 1/16 switched to 1:1 mid-period.
        write_cfg(32'h0000_00B0);
        wait_strobes(0, 2);
        early_test(0, 32'h0000_0000, 16, 1);

        // R7 on peripheral bus A: 1/16 switched to 1:1 mid-period.
        write_cfg(32'h0000_1C00);
        wait_strobes(1, 2);
        early_test(1, 32'h0000_0000, 16, 1);

        // R8: mid-run reset quiets strobes and restores defaults.
        write_cfg(32'h0000_64A2);
        wait_strobes(3, 2);
        @(negedge clk);
        rst_n = 1'b0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check("R8", int'({hb_stb, pb_stb, pb_tmr_stb, sys_tick_stb}), 0, "strobes in mid-run reset");
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", int'(src_sel), 0, "src cleared by reset");
        cnt = 0;
        for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            cnt += int'(hb_stb) + int'(pb_stb[1]);
        end
        check("R8", cnt, 128, "hb and bus B every cycle after reset");
        cnt = 0;
        for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            cnt += int'(sys_tick_stb);
        end
        check("R5", cnt, 8, "system ticks in 64 cycles at 1:1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule